// File: doc/BRIEF.md
# UART Channel Sleep Controller

This block decides when one UART channel may stop its UART clock and baud clock to save power, and when those clocks must start again. It runs on an always-on clock. It watches the channel's enable bits, line and FIFO status, pending interrupt sources, modem status pins, receive line and transmit-FIFO write strobe. Its main output is a registered clock-enable that a separate gating cell uses.

Sleep is granted only when every entry condition holds in the same cycle. At that moment the block records the receive line and the modem inputs. While asleep, the channel wakes when any of these happens:
- one of the recorded inputs moves away from its recorded value,
- the transmit FIFO is written,
- software withdraws either enable bit.

After a wake, a short hold-off stops the block from going straight back to sleep. A divisor-latch write strobe that arrives while asleep is a software protocol violation. It sets a sticky error flag.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After reset, `asleep` is 0, `clk_en` is 1 and `proto_err` is 0.
- R2: Sleep is entered only if `enh_en` and `slp_en` are both 1.
- R3: Sleep is entered only if `rx_idle`, `tx_fifo_empty`, `tx_shift_empty` and `rx_fifo_empty` are all 1 and `tx_wr` is 0 in the same cycle.
- R4: In `irq_pend`, bit 0 (transmit holding register empty) and bit 1 (receive timeout) never block entry. Any other set bit blocks entry.
- R5: When every entry condition holds at a clock edge, `asleep` reads 1 after that edge. `clk_en` always equals the inverse of `asleep`.
- R6: While asleep, a value on `rx_line` that differs from the value recorded at entry clears `asleep` at the next edge.
- R7: While asleep, a change on any single bit of `modem_in` relative to the recorded value clears `asleep` at the next edge.
- R8: While asleep, `tx_wr` high at an edge clears `asleep` at that edge.
- R9: While asleep, clearing `slp_en` or `enh_en` clears `asleep` at the next edge.
- R10: While asleep, changes on `rx_idle`, `rx_fifo_empty`, `tx_fifo_empty`, `tx_shift_empty` and `irq_pend` do not wake the channel.
- R11: After a wake, sleep is not re-entered for WAKE_HOLD (default 4) edges. It may be re-entered at the edge after that.
- R12: `dl_wr` high at an edge while asleep sets `proto_err`. The flag stays set until reset and does not wake the channel. `dl_wr` while awake has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_en | input | 1 | Enhanced-functions enable |
| slp_en | input | 1 | Sleep enable |
| rx_idle | input | 1 | Receive line idle |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| irq_pend | input | NIRQ | Pending interrupt sources; bit 0 THR empty, bit 1 timeout |
| modem_in | input | NMODEM | Modem status inputs |
| rx_line | input | 1 | Serial receive line |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| dl_wr | input | 1 | Divisor latch write strobe |
| clk_en | output | 1 | Enable for the UART and baud clocks |
| asleep | output | 1 | Channel is in sleep |
| proto_err | output | 1 | Sticky: divisor written while asleep |

## Verification
Every result is a single register stage away from its stimulus. A value driven before a rising edge therefore shows on `asleep`, `clk_en` or `proto_err` right after that edge.

The bench drives inputs on the falling edge and samples on the next falling edge. Each check therefore lands exactly one edge after its cause. The only exception is the hold-off, which is checked on each of the WAKE_HOLD following falling edges and then one edge later.

Entry conditions are swept exhaustively, with the expected value computed as a logical AND of the conditions. The interrupt vector is also swept exhaustively, with the expected value computed by masking out bits 0 and 1.

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
  parameter int NMODEM = 4,
  parameter int NIRQ = 6,
  parameter logic [NIRQ-1:0] ALLOW_MASK = 6'b000011,
  parameter int WAKE_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh_en,
  input  logic              slp_en,
  input  logic              rx_idle,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_empty,
  input  logic              rx_fifo_empty,
  input  logic [NIRQ-1:0]   irq_pend,
  input  logic [NMODEM-1:0] modem_in,
  input  logic              rx_line,
  input  logic              tx_wr,
  input  logic              dl_wr,
  output logic              clk_en,
  output logic              asleep,
  output logic              proto_err
);
  localparam int HW = $clog2(WAKE_HOLD + 2);

  logic              asleep_q;
  logic              cap_rx;
  logic [NMODEM-1:0] cap_modem;
  logic [HW-1:0]     hold_q;
  logic              err_q;

  wire en_ok     = enh_en & slp_en;
  wire quiet     = rx_idle & tx_fifo_empty & tx_shift_empty & rx_fifo_empty & ~tx_wr;
  wire irq_ok    = ~|(irq_pend & ~ALLOW_MASK);
  wire may_enter = en_ok & quiet & irq_ok & (hold_q == '0);
  wire wake      = (rx_line != cap_rx) | (modem_in != cap_modem) | tx_wr | ~en_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep_q  <= 1'b0;
      cap_rx    <= 1'b1;
      cap_modem <= '0;
      hold_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      if (asleep_q) begin
        if (dl_wr) err_q <= 1'b1;
        if (wake) begin
          asleep_q <= 1'b0;
          hold_q   <= HW'(WAKE_HOLD);
        end
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else if (may_enter) begin
        asleep_q  <= 1'b1;
        cap_rx    <= rx_line;
        cap_modem <= modem_in;
      end
    end
  end

  assign asleep    = asleep_q;
  assign clk_en    = ~asleep_q;
  assign proto_err = err_q;
endmodule

module uart_sleep_ctrl_chk #(
  parameter int NMODEM = 4,
  parameter int NIRQ = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enh_en,
  input logic              slp_en,
  input logic              rx_idle,
  input logic              tx_fifo_empty,
  input logic              tx_shift_empty,
  input logic              rx_fifo_empty,
  input logic [NIRQ-1:0]   irq_pend,
  input logic [NMODEM-1:0] modem_in,
  input logic              rx_line,
  input logic              tx_wr,
  input logic              dl_wr,
  input logic              clk_en,
  input logic              asleep,
  input logic              proto_err
);
  AST_ENABLES_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(enh_en && slp_en)); // R2
  AST_QUIET_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(rx_idle && tx_fifo_empty && tx_shift_empty && rx_fifo_empty && !tx_wr)); // R3
  AST_IRQ_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(irq_pend[NIRQ-1:2] == '0)); // R4
  AST_CLKEN_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en != asleep); // R5
  AST_RX_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && $past(asleep) && (rx_line != $past(rx_line)) |=> !asleep); // R6
  AST_MODEM_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && $past(asleep) && (modem_in != $past(modem_in)) |=> !asleep); // R7
  AST_TXWR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && tx_wr |=> !asleep); // R8
  AST_DISABLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && !(enh_en && slp_en) |=> !asleep); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> !asleep); // R11
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && dl_wr |=> proto_err); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R12
endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk #(.NMODEM(NMODEM), .NIRQ(NIRQ)) u_chk (.*);

// File: tb/uart_sleep_ctrl_test.sv
module uart_sleep_ctrl_test;
  localparam int NM = 4;
  localparam int NI = 6;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh_en, slp_en, rx_idle, tx_fifo_empty, tx_shift_empty, rx_fifo_empty;
  logic [NI-1:0] irq_pend;
  logic [NM-1:0] modem_in;
  logic rx_line, tx_wr, dl_wr;
  logic clk_en, asleep, proto_err;
  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_sleep_ctrl #(.NMODEM(NM), .NIRQ(NI), .WAKE_HOLD(HOLD)) uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic good();
    enh_en = 1; slp_en = 1; rx_idle = 1; tx_fifo_empty = 1; tx_shift_empty = 1;
    rx_fifo_empty = 1; irq_pend = '0; modem_in = '0; rx_line = 1; tx_wr = 0; dl_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    good();
    enh_en = 0;
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic go_sleep();
    do_reset();
    good();
    @(negedge clk);
    chk("R5 entry", asleep, 1'b1);
  endtask

  initial begin
    good();
    do_reset();
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 clk_en", clk_en, 1'b1);
    chk("R1 proto_err", proto_err, 1'b0);

    // R2 R3 R5: sweep over enables, quiet flags and tx_wr
    for (int v = 0; v < 128; v++) begin
      do_reset();
      good();
      {enh_en, slp_en, rx_idle, tx_fifo_empty, tx_shift_empty, rx_fifo_empty} = v[5:0];
      tx_wr = v[6];
      @(negedge clk);
      chk("R2/R3 entry sweep", asleep, (v == 63));
      chk("R5 clk_en", clk_en, (v != 63));
    end

    // R4: sweep of interrupt sources
    for (int v = 0; v < 64; v++) begin
      do_reset();
      good();
      irq_pend = v[5:0];
      @(negedge clk);
      chk("R4 irq sweep", asleep, ((v & 60) == 0));
    end

    // R6
    go_sleep();
    rx_line = 0;
    @(negedge clk);
    chk("R6 rx wake", asleep, 1'b0);

    // R7: each modem bit
    for (int b = 0; b < NM; b++) begin
      go_sleep();
      modem_in[b] = 1'b1;
      @(negedge clk);
      chk("R7 modem wake", asleep, 1'b0);
    end

    // R8
    go_sleep();
    tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
    chk("R8 tx write wake", asleep, 1'b0);

    // R9
    go_sleep();
    slp_en = 0;
    @(negedge clk);
    chk("R9 slp_en clear", asleep, 1'b0);
    go_sleep();
    enh_en = 0;
    @(negedge clk);
    chk("R9 enh_en clear", asleep, 1'b0);

    // R10: non-wake inputs while asleep
    go_sleep();
    rx_idle = 0; rx_fifo_empty = 0; tx_fifo_empty = 0; tx_shift_empty = 0; irq_pend = '1;
    @(negedge clk);
    chk("R10 no wake", asleep, 1'b1);
    @(negedge clk);
    chk("R10 no wake later", asleep, 1'b1);

    // R11: hold-off after wake
    go_sleep();
    rx_line = 0;
    @(negedge clk);
    chk("R11 woke", asleep, 1'b0);
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk);
      chk("R11 hold-off", asleep, 1'b0);
    end
    @(negedge clk);
    chk("R11 re-entry", asleep, 1'b1);

    // R12
    do_reset();
    dl_wr = 1;
    @(negedge clk);
    dl_wr = 0;
    chk("R12 awake dl_wr", proto_err, 1'b0);
    good();
    @(negedge clk);
    chk("R12 asleep", asleep, 1'b1);
    dl_wr = 1;
    @(negedge clk);
    dl_wr = 0;
    chk("R12 err set", proto_err, 1'b1);
    chk("R12 no wake", asleep, 1'b1);
    tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
    @(negedge clk);
    chk("R12 sticky", proto_err, 1'b1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule